// File: doc/BRIEF.md
# Masked priority interrupt controller

This block gathers thirteen level-sensitive interrupt lines into a pending register. A mask register can block any of them. Each source has an 8-bit control register, and its low five bits are the source's priority. Every cycle the block picks the unmasked pending source with the greatest priority and reports three things to the processor: a 3-bit interrupt level, the index of the winning source, and an autovector number. On the usual integration, the two timers feed sources 9 and 10 and the two serial ports feed sources 12 and 13.

Software sets up the controller through a single-cycle register port. Writes are synchronous. Reads are combinational from the address. The outputs are registered, so a change on an input line or a register write shows up at the outputs one clock edge after it has been captured.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source k (1 to 13) is input bit src_i[k-1]. The pending bit for source k is a copy of src_i[k-1] taken at every clock edge, so it is 1 while the line is high and 0 while it is low. Address 15 reads the pending bits in rdata_o[12:0], with bit k-1 holding source k.
- R2: After reset, every mask bit is 1, every control register is 0 and all pending bits are 0. While reset is asserted, irq_level_o, irq_src_o and rdata-visible state are 0, and irq_vec_o is 24.
- R3: Mask bit k-1 (address 14, bits [12:0]) set to 1 blocks source k. Only sources that are both pending and unmasked take part in arbitration.
- R4: The winner is the candidate with the greatest priority field, which is control bits [4:0]. A candidate whose priority field is 0 never wins.
- R5: When two candidates have equal priority, the lower-numbered source wins.
- R6: irq_src_o gives the winner's number (1 to 13) and irq_level_o gives the winner's control bits [4:2]. When there is no winner, both are 0.
- R7: irq_vec_o always equals 24 + irq_level_o.
- R8: Register map. Addresses 1 to 13 read and write the control register of source k = address, zero-extended on read. Address 14 is the mask. Address 15 is read-only. Writes to addresses 0 and 15 have no effect, and a read of address 0 returns 0.
- R9: An input change or a register write captured at clock edge n is reflected on irq_level_o, irq_src_o and irq_vec_o after edge n+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 13 | Interrupt lines, bit k-1 is source k |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| irq_level_o | output | 3 | Interrupt level to processor |
| irq_src_o | output | 4 | Winning source number, 0 when none |
| irq_vec_o | output | 8 | Autovector number |

## Verification
Arbitration is tried with several priority layouts on all lines at once:
- Distinct priorities check that the largest value wins regardless of its position.
- Equal priorities on non-adjacent sources check that the lower number wins.
- A lone priority-0 candidate checks that such a source is treated as idle.

Masking is tried one source at a time against a fully pending input set. Dropping the current winner's line checks that the next-best source takes over. A single line toggle, sampled one cycle at a time, separates the pending capture edge from the output edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC  = 13;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned PRIO_W   = 5;
  localparam int unsigned LVL_W    = 3;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned VEC_BASE = 24;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_SRC = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= src_i;
  end

  assign pend_o = pend_q;

  assert_pend_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> pend_q == $past(src_i));
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [NUM_SRC-1:0]        pend_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NUM_SRC-1:0]        mask_o,
  output logic [NUM_SRC*CTRL_W-1:0] ctrl_o
);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_SRC + 1);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(NUM_SRC + 2);

  logic [NUM_SRC-1:0] mask_q;
  logic [CTRL_W-1:0]  ctrl_q [NUM_SRC];
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ctrl_q[g] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(g + 1))
        ctrl_q[g] <= wdata_i[CTRL_W-1:0];
    end
    assign ctrl_o[g*CTRL_W +: CTRL_W] = ctrl_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mask_q <= '1;
    else if (wr_en_i && addr_i == MASK_ADDR)
      mask_q <= wdata_i[NUM_SRC-1:0];
  end

  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (addr_i == ADDR_W'(i + 1)) rdata_o = DATA_W'(ctrl_q[i]);
    if (addr_i == MASK_ADDR) rdata_o = DATA_W'(mask_q);
    if (addr_i == PEND_ADDR) rdata_o = DATA_W'(pend_i);
  end

  assert_mask_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> mask_q == '1);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned PRIO_W  = 5,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0]        cand_i,
  input  logic [NUM_SRC*CTRL_W-1:0] ctrl_i,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic [LVL_W-1:0]          win_lvl_o
);
  logic [PRIO_W-1:0] best;
  logic [PRIO_W-1:0] prio;
  logic              unused_ctrl;

  assign unused_ctrl = ^ctrl_i;

  // Ascending scan, strict compare: ties keep the lower index, prio 0 never wins.
  always_comb begin
    best      = '0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      prio = ctrl_i[i*CTRL_W +: PRIO_W];
      if (cand_i[i] && prio > best) begin
        best      = prio;
        win_idx_o = IDX_W'(i + 1);
        win_lvl_o = prio[PRIO_W-1 -: LVL_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned A_W    = ADDR_W,
  parameter int unsigned D_W    = DATA_W,
  parameter int unsigned L_W    = LVL_W,
  parameter int unsigned V_W    = VEC_W,
  parameter int unsigned V_BASE = VEC_BASE,
  localparam int unsigned I_W   = $clog2(N_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic [A_W-1:0]   addr_i,
  input  logic [D_W-1:0]   wdata_i,
  output logic [D_W-1:0]   rdata_o,
  output logic [L_W-1:0]   irq_level_o,
  output logic [I_W-1:0]   irq_src_o,
  output logic [V_W-1:0]   irq_vec_o
);
  logic [N_SRC-1:0]        pend, mask, cand;
  logic [N_SRC*CTRL_W-1:0] ctrl;
  logic [I_W-1:0]          win_idx, idx_q;
  logic [L_W-1:0]          win_lvl, lvl_q;

  irq_pending #(.NUM_SRC(N_SRC)) u_pend (
    .clk_i, .rst_ni, .src_i, .pend_o(pend)
  );

  irq_regs #(.NUM_SRC(N_SRC), .CTRL_W(CTRL_W), .ADDR_W(A_W), .DATA_W(D_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .pend_i(pend), .rdata_o, .mask_o(mask), .ctrl_o(ctrl)
  );

  assign cand = pend & ~mask;

  irq_arbiter #(.NUM_SRC(N_SRC), .CTRL_W(CTRL_W), .PRIO_W(PRIO_W), .LVL_W(L_W),
                .IDX_W(I_W)) u_arb (
    .cand_i(cand), .ctrl_i(ctrl), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      lvl_q <= '0;
    end else begin
      idx_q <= win_idx;
      lvl_q <= win_lvl;
    end
  end

  assign irq_src_o   = idx_q;
  assign irq_level_o = lvl_q;
  assign irq_vec_o   = V_W'(V_BASE) + V_W'(lvl_q);

  assert_idle_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_src_o == '0 |-> irq_level_o == '0);

  assert_winner_unmasked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && irq_src_o != '0) |->
      ((($past(cand) >> (irq_src_o - 1'b1)) & N_SRC'(1)) != '0));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  lvl;
  logic [3:0]  sidx;
  logic [7:0]  vec;

  int total = 0;
  int bad = 0;
  logic [7:0]  m_ctrl [13];
  logic [12:0] m_mask;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_level_o(lvl), .irq_src_o(sidx),
    .irq_vec_o(vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 1 && a <= 13) m_ctrl[a-1] = 8'(d);
    if (a == 14) m_mask = 13'(d);
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = 4'(a);
    #1 d = int'(rdata);
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic check_out(input string tag);
    int best, ei, el;
    best = 0; ei = 0; el = 0;
    for (int k = 0; k < 13; k++)
      if (src[k] && !m_mask[k] && int'(m_ctrl[k] & 8'h1f) > best) begin
        best = int'(m_ctrl[k] & 8'h1f);
        ei = k + 1;
      end
    if (ei != 0) el = int'((m_ctrl[ei-1] >> 2) & 8'h7);
    chk({tag, " src"}, int'(sidx), ei);
    chk({tag, " level"}, int'(lvl), el);
    chk({"R7 ", tag, " vec"}, int'(vec), 24 + el);
  endtask

  task automatic t_reset();
    int d;
    src = '1;
    repeat (3) @(negedge clk);
    chk("R2 level in reset", int'(lvl), 0);
    chk("R2 src in reset", int'(sidx), 0);
    chk("R7 vec in reset", int'(vec), 24);
    rst_n = 1'b1;
    settle();
    chk("R2 level after reset, masked", int'(lvl), 0);
    rd(14, d); chk("R2 mask reset", d, 16'h1fff);
    rd(7, d);  chk("R2 ctrl reset", d, 0);
    rd(15, d); chk("R1 pending all high", d, 16'h1fff);
  endtask

  task automatic t_regs();
    int d;
    wr(5, 16'hffa7);
    rd(5, d);  chk("R8 ctrl readback", d, 16'h00a7);
    wr(0, 16'h1234);
    rd(0, d);  chk("R8 addr0 reads 0", d, 0);
    src = 13'h0a5a;
    wr(15, 16'h0000);
    rd(15, d); chk("R8 pend write ignored", d, 16'h0a5a);
    chk("R1 pending pattern", d, 16'h0a5a);
    rd(14, d); chk("R8 mask unchanged", d, 16'h1fff);
    wr(5, 0);
  endtask

  task automatic t_mask();
    for (int k = 1; k <= 13; k++) wr(k, k + 8);
    src = '1;
    wr(14, 16'h1fff); settle();
    check_out("R3 all masked");
    wr(14, 16'h1eff); settle();
    check_out("R3 only src9 open");
    chk("R3 src9 wins", int'(sidx), 9);
    wr(14, 16'h0eff); settle();
    check_out("R3 src13 open");
    chk("R3 src13 wins", int'(sidx), 13);
  endtask

  task automatic t_prio();
    wr(14, 0);
    for (int k = 1; k <= 13; k++) wr(k, (k * 7) % 32);
    src = '1; settle();
    check_out("R4 distinct prio");
    chk("R4 winner", int'(sidx), 9);
    chk("R6 level of prio 31", int'(lvl), 7);
    src[8] = 1'b0; settle();
    check_out("R4 winner dropped");
    src = 13'h0404; settle();
    check_out("R6 sparse lines");
  endtask

  task automatic t_tie();
    for (int k = 1; k <= 13; k++) wr(k, 3);
    wr(4, 16'h0014); wr(11, 16'h0014); wr(12, 16'h0014);
    src = '1; settle();
    chk("R5 tie lower wins", int'(sidx), 4);
    chk("R6 tie level", int'(lvl), 5);
    src[3] = 1'b0; settle();
    chk("R5 tie next lower", int'(sidx), 11);
    check_out("R5 tie");
  endtask

  task automatic t_zero();
    for (int k = 1; k <= 13; k++) wr(k, 0);
    wr(6, 16'h00e0);
    src = '1; settle();
    chk("R4 prio0 ignored", int'(sidx), 0);
    chk("R6 no winner level", int'(lvl), 0);
    wr(6, 16'h0001); settle();
    chk("R4 prio1 wins", int'(sidx), 6);
    chk("R6 prio1 level", int'(lvl), 0);
  endtask

  task automatic t_latency();
    wr(2, 16'h000b);
    src = '0; settle();
    chk("R9 idle", int'(sidx), 0);
    addr = 4'd15;
    @(negedge clk); src[1] = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 pending after one edge", int'(rdata), 2);
    chk("R9 not yet", int'(sidx), 0);
    @(posedge clk); @(negedge clk);
    chk("R9 after second edge", int'(sidx), 2);
    chk("R6 level 2", int'(lvl), 2);
    wr(14, 16'h0002);
    chk("R9 write not yet", int'(sidx), 2);
    @(posedge clk); @(negedge clk);
    chk("R9 write applied", int'(sidx), 0);
  endtask

  initial begin
    for (int k = 0; k < 13; k++) m_ctrl[k] = '0;
    m_mask = '1;
    t_reset();
    t_regs();
    t_mask();
    t_prio();
    t_tie();
    t_zero();
    t_latency();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule